// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM Datapath

This block holds the storage and the data path of a synchronous static RAM whose 18-bit word is split into two 9-bit byte lanes. Every control except the output enable is captured on the rising clock edge. A selected cycle is either a write or a read. A write can be global, which updates every lane. It can also be per-lane, which updates only the lanes whose select bit is set while the byte-write enable is high. Any selected cycle that writes no lane is a read. The word address comes from an external burst counter or controller, so this block only consumes it.

A static mode input sets the read timing. In flow-through mode the word read from the captured address goes straight to the output. In pipelined mode that word passes through one more rising-edge register first. Counting the edge that samples the requester's address and the edge at which the requester takes the data, this gives 2-1-1-1 and 3-1-1-1 burst timing. A deselect skips the extra stage, so the output drive turns off right after the deselect is captured, even in pipelined mode. The output enable gates the drive combinationally. `dq_en` is the pad enable for the shared bus: the pad is high impedance while it is low, and `dq` is held at zero then.

Top module: `sram_dp`

## Requirements
- R1: After reset, and until a read has been captured, `dq_en` is 0.
- R2: A selected cycle with `gwe`=1 writes all 18 bits of `wdata` to `addr`, whatever the values of `bwe` and `bsel`.
- R3: A selected cycle with `gwe`=0, `bwe`=1 writes only the lanes whose `bsel` bit is 1. Lane 0 is bits 8:0 and lane 1 is bits 17:9. The other lane keeps its old contents.
- R4: A selected cycle with `gwe`=0 and either `bwe`=0 or `bsel`=0 writes nothing and is a read of `addr`.
- R5: With `pipe_mode`=0, a read captured at edge k puts the word at that address on `dq` with `dq_en`=1 from just after edge k until edge k+1 (given `oe`=1).
- R6: With `pipe_mode`=1, a read captured at edge k puts its word on `dq` from just after edge k+1 until edge k+2. The word is the contents before any write captured at edge k+1.
- R7: Back-to-back reads produce one new word per clock in both modes.
- R8: A deselect (`cs`=0) captured at edge k drives `dq_en` to 0 right after edge k in both modes. In pipelined mode this holds even when edge k-1 captured a read.
- R9: `oe`=0 forces `dq_en` to 0 at once, with no clock edge. When `oe` returns to 1, the pending read data reappears at once.
- R10: A write cycle never drives its own data. In flow-through mode `dq_en` is 0 after its capture edge. In pipelined mode it is 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| pipe_mode | input | 1 | 1 = pipelined reads, 0 = flow-through reads (static) |
| oe | input | 1 | Asynchronous output enable, active high |
| cs | input | 1 | Chip select, sampled |
| gwe | input | 1 | Global write, writes all lanes |
| bwe | input | 1 | Byte-write enable, qualifies `bsel` |
| bsel | input | 2 | Per-lane write selects |
| addr | input | 6 | Word address |
| wdata | input | 18 | Write data |
| dq | output | 18 | Read data toward the pad |
| dq_en | output | 1 | Pad drive enable; the bus floats when 0 |

## Verification
The assertions check on every cycle the rules that govern the drive enable. A captured deselect turns it off on the next cycle. A low `oe` keeps it off. A flow-through write leaves it off. A flow-through read with `oe` high turns it on. Only the bench scenarios can show that stored values are right after global writes, single-lane writes and rejected byte writes. The same holds for the two- and three-clock read latencies with old-data ordering in the pipelined stage, and for the data reappearing when `oe` is raised between edges.

// File: rtl/sram_dp.sv
module sram_dp #(
  parameter int AW    = 6,
  parameter int LW    = 9,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pipe_mode,
  input  logic                  oe,
  input  logic                  cs,
  input  logic                  gwe,
  input  logic                  bwe,
  input  logic [LANES-1:0]      bsel,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   wdata,
  output logic [LANES*LW-1:0]   dq,
  output logic                  dq_en
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [LANES-1:0] lane_wr;
  logic             wr_any, rd_now;
  logic [AW-1:0]    addr_q;
  logic             rd_q, rd_q2, cs_q;
  logic [DW-1:0]    rdat, pipe_q;

  assign lane_wr = {LANES{cs}} & ({LANES{gwe}} | ({LANES{bwe}} & bsel));
  assign wr_any  = |lane_wr;
  assign rd_now  = cs & ~wr_any;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (lane_wr[g]) mem[addr] <= wdata[g*LW +: LW];
    assign rdat[g*LW +: LW] = mem[addr_q];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      rd_q2  <= 1'b0;
      cs_q   <= 1'b0;
      pipe_q <= '0;
    end else begin
      addr_q <= addr;
      rd_q   <= rd_now;
      rd_q2  <= rd_q;
      cs_q   <= cs;
      pipe_q <= rdat;
    end

  assign dq_en = oe & (pipe_mode ? (rd_q2 & cs_q) : rd_q);
  assign dq    = dq_en ? (pipe_mode ? pipe_q : rdat) : '0;
endmodule

// File: rtl/sram_dp_chk.sv
module sram_dp_chk #(
  parameter int LANES = 2,
  parameter int DW    = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             oe,
  input logic             cs,
  input logic             gwe,
  input logic             bwe,
  input logic [LANES-1:0] bsel,
  input logic [DW-1:0]    dq,
  input logic             dq_en
);
  logic is_wr;
  assign is_wr = cs && (gwe || (bwe && (|bsel)));

  a_r8_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !dq_en);

  a_r9_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_en);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_en |-> (dq == '0));

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && !pipe_mode) |=> (!dq_en || pipe_mode));

  a_r5_flow_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !is_wr && oe && !pipe_mode) |=> (dq_en || !oe || pipe_mode));
endmodule

bind sram_dp sram_dp_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .cs(cs),
  .gwe(gwe), .bwe(bwe), .bsel(bsel), .dq(dq), .dq_en(dq_en)
);

// File: tb/tb_sram_dp.sv
`timescale 1ns/100ps
module tb_sram_dp;
  localparam int AW = 6, LW = 9, LANES = 2, DW = 18;

  logic clk = 0, rst_n = 0, pipe_mode = 0, oe = 1, cs = 0, gwe = 0, bwe = 0;
  logic [LANES-1:0] bsel = '0;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    wdata = '0;
  logic [DW-1:0]    dq;
  logic             dq_en;

  sram_dp #(.AW(AW), .LW(LW), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .oe(oe), .cs(cs),
    .gwe(gwe), .bwe(bwe), .bsel(bsel), .addr(addr), .wdata(wdata),
    .dq(dq), .dq_en(dq_en));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [1<<AW];
  bit            p_rd = 0;
  logic [DW-1:0] p_data = '0;
  bit            en_q[$];
  logic [DW-1:0] d_q[$];
  string         t_q[$];

  task automatic fail(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
    errors++;
    $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic cyc(input bit c, input bit g, input bit b, input logic [1:0] s,
                     input logic [AW-1:0] a, input logic [DW-1:0] w, input string tag);
    bit wr, rd, en;
    logic [DW-1:0] d, old;
    @(negedge clk);
    cs = c; gwe = g; bwe = b; bsel = s; addr = a; wdata = w;
    wr  = c && (g || (b && s != 0));
    rd  = c && !wr;
    old = model[a];
    if (!pipe_mode) begin en = oe && rd;          d = old;    end
    else            begin en = oe && p_rd && c;   d = p_data; end
    en_q.push_back(en); d_q.push_back(d); t_q.push_back(tag);
    if (wr)
      for (int i = 0; i < LANES; i++)
        if (g || s[i]) model[a][i*LW +: LW] = w[i*LW +: LW];
    p_rd = rd;
    if (rd) p_data = old;
  endtask

  task automatic set_mode(input bit m);
    @(posedge clk); #3;
    pipe_mode = m;
  endtask

  task automatic oe_check(input logic [DW-1:0] exp);
    @(posedge clk); #3;
    oe = 0; #0.5;
    checks++;
    if (dq_en !== 1'b0) fail("R9", "dq_en with oe low", {17'd0, dq_en}, '0);
    oe = 1; #0.5;
    checks++;
    if (dq_en !== 1'b1 || dq !== exp) fail("R9", "dq after oe high", dq, exp);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (en_q.size() > 0) begin
        bit e; logic [DW-1:0] d; string t;
        e = en_q.pop_front(); d = d_q.pop_front(); t = t_q.pop_front();
        checks++;
        if (dq_en !== e) fail(t, "dq_en", {17'd0, dq_en}, {17'd0, e});
        else if (e && dq !== d) fail(t, "dq", dq, d);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (dq_en !== 1'b0) fail("R1", "dq_en in reset", {17'd0, dq_en}, '0);
    rst_n = 1;
    @(negedge clk); #1;
    checks++;
    if (dq_en !== 1'b0) fail("R1", "dq_en after reset", {17'd0, dq_en}, '0);

    // flow-through: global writes ignore bwe/bsel
    cyc(1, 1, 0, 2'b00, 0, 18'h2A5B3, "R2");
    cyc(1, 1, 1, 2'b01, 1, 18'h1C0DE, "R2");
    cyc(1, 1, 0, 2'b10, 2, 18'h30F0F, "R2");
    cyc(1, 1, 0, 2'b00, 3, 18'h15555, "R2");
    // per-lane writes
    cyc(1, 0, 1, 2'b01, 1, 18'h3FFFF, "R3");
    cyc(1, 0, 1, 2'b10, 2, 18'h00000, "R3");
    // rejected byte writes become reads
    cyc(1, 0, 1, 2'b00, 3, 18'h0AAAA, "R4");
    cyc(1, 0, 0, 2'b11, 3, 18'h0AAAA, "R4");
    // back-to-back flow reads
    cyc(1, 0, 0, 2'b00, 0, '0, "R5");
    cyc(1, 0, 0, 2'b00, 1, '0, "R7");
    cyc(1, 0, 0, 2'b00, 2, '0, "R7");
    cyc(1, 0, 0, 2'b00, 3, '0, "R7");
    cyc(0, 0, 0, 2'b00, 0, '0, "R8");
    cyc(1, 1, 0, 2'b00, 4, 18'h12345, "R10");
    cyc(1, 0, 0, 2'b00, 4, '0, "R2");
    cyc(1, 0, 0, 2'b00, 1, '0, "R5");
    oe_check(model[1]);

    // pipelined
    set_mode(1);
    cyc(1, 0, 0, 2'b00, 0, '0, "R6");
    cyc(1, 0, 0, 2'b00, 1, '0, "R6");
    cyc(1, 0, 0, 2'b00, 2, '0, "R7");
    cyc(1, 0, 0, 2'b00, 3, '0, "R7");
    cyc(0, 0, 0, 2'b00, 0, '0, "R8");
    cyc(0, 0, 0, 2'b00, 0, '0, "R8");
    cyc(1, 0, 0, 2'b00, 2, '0, "R6");
    cyc(1, 1, 0, 2'b00, 2, 18'h0BEEF, "R6");
    cyc(0, 0, 0, 2'b00, 0, '0, "R10");
    cyc(1, 0, 0, 2'b00, 2, '0, "R2");
    cyc(1, 0, 1, 2'b11, 5, 18'h2F00D, "R3");
    cyc(1, 0, 1, 2'b00, 5, 18'h11111, "R4");
    cyc(1, 0, 0, 2'b00, 0, '0, "R6");
    oe_check(model[5]);
    cyc(0, 0, 0, 2'b00, 0, '0, "R8");
    cyc(0, 0, 0, 2'b00, 0, '0, "R8");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule